// File: doc/BRIEF.md
# Radix-4 Iterative Multiply-High and Divide Unit

This block computes the upper 32 bits of a 32×32 product (signed×signed, signed×unsigned or unsigned×unsigned), and the quotient or remainder of a signed or unsigned 32-bit division. It works through two bits of the operation on every clock. Negative operands are first turned into magnitudes. The unsigned core then runs 16 iteration cycles, and the sign of the result is corrected afterwards where needed. The correction cycles are taken only when an operand is negative, so the latency is fixed by the opcode and the operand signs, never by the operand values.

A client raises `start_i` for one cycle with an opcode and two operands while `busy_o` is low. `busy_o` stays high until the cycle in which `done_o` pulses and `result_o` carries the answer.

The controller has five states:
- `ST_IDLE` waits for a start.
- `ST_ABS` negates negative operands.
- `ST_ITER` runs 16 two-bit steps.
- `ST_NEG` negates a negative high product.
- `ST_DONE` presents the result.

Transitions:
- IDLE→ABS when a start is accepted and a signed operand is negative; IDLE→ITER when a start is accepted and no signed operand is negative.
- ABS→ITER always.
- ITER→ITER until the last step.
- ITER→NEG after the last step of a multiply whose product is negative; ITER→DONE after the last step otherwise.
- NEG→DONE always.
- DONE→IDLE always.

Top module: `seq_muldiv`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy_o` and `done_o` are low.
- R2: Opcode 3'b010 or 3'b011 returns bits 63:32 of the unsigned product of `a_i` and `b_i`. The latency is 18 cycles, counting the start cycle and the done cycle.
- R3: Opcode 3'b000 returns the high word of the signed×signed product. Opcode 3'b001 returns the high word of signed `a_i` times unsigned `b_i`.
- R4: A multiply takes 18 cycles, plus 1 if any signed operand is negative, plus 1 more if exactly one signed operand is negative (that is, the product is negative). This gives 18 to 20 cycles.
- R5: Opcode 3'b101 returns the unsigned quotient `a_i / b_i`, and 3'b111 returns the unsigned remainder. Both take 18 cycles.
- R6: Opcode 3'b100 returns the signed quotient, truncated toward zero, and 3'b110 returns the signed remainder. The quotient is negative when exactly one operand is negative, and the remainder takes the dividend's sign. Both take 18 cycles, or 19 if any operand is negative.
- R7: Division by zero returns all ones as the quotient and the dividend as the remainder, for both signed and unsigned opcodes.
- R8: A signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000 as the quotient and zero as the remainder.
- R9: `done_o` is high for exactly one cycle. `busy_o` is high from the cycle after an accepted start through the done cycle. A start raised while `busy_o` is high, including in the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while not busy |
| op_i | input | 3 | Operation code (see R2–R6) |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 32 | Result, valid while `done_o` is high, zero otherwise |

## Verification
The bench measures the latency of every operation alongside its value. A controller that took the magnitude or negation cycle unconditionally, or skipped it when an operand is negative, shows up as a cycle-count mismatch even when the result is right.

The sign corner cases are all exercised: both operands negative, a negative operand paired with zero, and the largest negative value squared. A design that kept the sign fix when the divisor is zero would return 1 instead of all ones. A design that mishandled the overflow divide would return zero or a positive value. Start pulses injected mid-operation and in the done cycle would corrupt the result or restart the unit if they were not ignored.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ABS,
        ST_ITER,
        ST_NEG,
        ST_DONE
    } smd_state_e;

    // op[2]: divide family; op[1]: remainder (div) / unsigned a (mul)
    // op[0]: unsigned (div)
    localparam logic [2:0] OP_MULH   = 3'b000;
    localparam logic [2:0] OP_MULHSU = 3'b001;
    localparam logic [2:0] OP_MULHU  = 3'b010;
    localparam logic [2:0] OP_DIV    = 3'b100;
    localparam logic [2:0] OP_DIVU   = 3'b101;
    localparam logic [2:0] OP_REM    = 3'b110;
    localparam logic [2:0] OP_REMU   = 3'b111;

endpackage

// File: rtl/smd_cond_neg.sv
module smd_cond_neg #(
    parameter int W = 32
) (
    input  logic         en,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    assign y = en ? (~x + 1'b1) : x;
endmodule

// File: rtl/smd_mul_step.sv
module smd_mul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mpl,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] acc_n,
    output logic [W-1:0] mpl_n
);
    logic [W+1:0] part;
    logic [W+1:0] sum;

    always_comb begin
        part = ({2'b00, mcand} & {(W+2){mpl[0]}})
             + ({1'b0, mcand, 1'b0} & {(W+2){mpl[1]}});
        sum  = {2'b00, acc} + part;
    end

    assign acc_n = sum[W+1:2];
    assign mpl_n = {sum[1:0], mpl[W-1:2]};
endmodule

// File: rtl/smd_div_step.sv
module smd_div_step #(
    parameter int W     = 32,
    parameter int STEPS = 2
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_n,
    output logic [W-1:0] quo_n
);
    logic [W-1:0] rem_c [0:STEPS];
    logic [W-1:0] quo_c [0:STEPS];

    assign rem_c[0] = rem;
    assign quo_c[0] = quo;

    for (genvar i = 0; i < STEPS; i++) begin : g_sub
        logic [W:0] shifted;
        logic [W:0] diff;
        logic       ge;
        assign shifted      = {rem_c[i], quo_c[i][W-1]};
        assign ge           = shifted >= {1'b0, dvs};
        assign diff         = shifted - {1'b0, dvs};
        assign rem_c[i+1]   = ge ? diff[W-1:0] : shifted[W-1:0];
        assign quo_c[i+1]   = {quo_c[i][W-2:0], ge};
    end

    assign rem_n = rem_c[STEPS];
    assign quo_n = quo_c[STEPS];
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv
    import smd_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam int STEP_BITS = 2;
    localparam int ITERS     = WIDTH / STEP_BITS;
    localparam int CW        = $clog2(ITERS);
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    smd_state_e state_q, state_d;

    logic [2:0]       op_q;
    logic             na_q, nb_q;
    logic [WIDTH-1:0] x_q, y_q, hi_q;
    logic [CW-1:0]    cnt_q;

    // ---------------- start decode ----------------
    logic is_div_i, sgn_a_i, sgn_b_i, na_i, nb_i;
    always_comb begin
        is_div_i = op_i[2];
        sgn_a_i  = is_div_i ? !op_i[0] : (op_i[1] == 1'b0);
        sgn_b_i  = is_div_i ? !op_i[0] : (op_i[1:0] == 2'b00);
        na_i     = sgn_a_i & a_i[WIDTH-1];
        nb_i     = sgn_b_i & b_i[WIDTH-1];
    end

    logic is_div_q, is_rem_q, mul_neg;
    assign is_div_q = op_q[2];
    assign is_rem_q = op_q[1];
    assign mul_neg  = !is_div_q && (na_q ^ nb_q);

    // ---------------- datapath pieces ----------------
    logic [WIDTH-1:0] x_mag, y_mag;
    smd_cond_neg #(.W(WIDTH)) i_abs_x (
        .en (is_div_q ? nb_q : na_q),
        .x  (x_q),
        .y  (x_mag)
    );
    smd_cond_neg #(.W(WIDTH)) i_abs_y (
        .en (is_div_q ? na_q : nb_q),
        .x  (y_q),
        .y  (y_mag)
    );

    logic [WIDTH-1:0] acc_n, mpl_n;
    smd_mul_step #(.W(WIDTH)) i_mul_step (
        .acc   (hi_q),
        .mpl   (y_q),
        .mcand (x_q),
        .acc_n (acc_n),
        .mpl_n (mpl_n)
    );

    logic [WIDTH-1:0] rem_n, quo_n;
    smd_div_step #(.W(WIDTH), .STEPS(STEP_BITS)) i_div_step (
        .rem   (hi_q),
        .quo   (y_q),
        .dvs   (x_q),
        .rem_n (rem_n),
        .quo_n (quo_n)
    );

    logic             div_fix;
    logic [WIDTH-1:0] div_sel, div_res;
    always_comb begin
        div_sel = is_rem_q ? hi_q : y_q;
        div_fix = is_rem_q ? na_q : ((na_q ^ nb_q) && (x_q != '0));
    end
    smd_cond_neg #(.W(WIDTH)) i_fix_div (
        .en (div_fix),
        .x  (div_sel),
        .y  (div_res)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = (na_i || nb_i) ? ST_ABS : ST_ITER;
            ST_ABS:  state_d = ST_ITER;
            ST_ITER: if (cnt_q == LAST) state_d = mul_neg ? ST_NEG : ST_DONE;
            ST_NEG:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            na_q  <= 1'b0;
            nb_q  <= 1'b0;
            x_q   <= '0;
            y_q   <= '0;
            hi_q  <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    op_q  <= op_i;
                    na_q  <= na_i;
                    nb_q  <= nb_i;
                    x_q   <= is_div_i ? b_i : a_i;
                    y_q   <= is_div_i ? a_i : b_i;
                    hi_q  <= '0;
                    cnt_q <= '0;
                end
                ST_ABS: begin
                    x_q <= x_mag;
                    y_q <= y_mag;
                end
                ST_ITER: begin
                    hi_q  <= is_div_q ? rem_n : acc_n;
                    y_q   <= is_div_q ? quo_n : mpl_n;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_NEG: hi_q <= ~hi_q + {{(WIDTH-1){1'b0}}, (y_q == '0)};
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_DONE);
        result_o = '0;
        if (state_q == ST_DONE) result_o = is_div_q ? div_res : hi_q;
    end

    // ---------------- assertions ----------------
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    a_r9_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(op_q) && $stable(na_q) && $stable(nb_q)));

    a_r2_iter_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && cnt_q != LAST) |=> (state_q == ST_ITER));

    a_r4_neg_mul_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEG) |-> (!is_div_q && (na_q != nb_q)));

    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && is_div_q && !is_rem_q && x_q == '0) |-> (result_o == '1));

endmodule

// File: tb/test_seq_muldiv.sv
`timescale 1ns/1ps
module test_seq_muldiv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    localparam logic [2:0] MULH = 3'b000, MULHSU = 3'b001, MULHU = 3'b010;
    localparam logic [2:0] DIV = 3'b100, DIVU = 3'b101, REM = 3'b110, REMU = 3'b111;

    always #2.5 clk = ~clk;

    seq_muldiv i_seq_muldiv (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_result(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ea, eb, p;
        logic [31:0] q, r;
        if (!op[2]) begin
            ea = (op[1] == 1'b0)    ? {{32{a[31]}}, a} : {32'h0, a};
            eb = (op[1:0] == 2'b00) ? {{32{b[31]}}, b} : {32'h0, b};
            p  = ea * eb;
            return p[63:32];
        end
        if (b == 0) begin
            q = '1; r = a;
        end else if (!op[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = a; r = 0;
        end else if (op[0]) begin
            q = a / b; r = a % b;
        end else begin
            q = $signed(a) / $signed(b);
            r = $signed(a) % $signed(b);
        end
        return op[1] ? r : q;
    endfunction

    function automatic int ref_lat(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        bit na, nb;
        if (!op[2]) begin
            na = (op[1] == 1'b0) && a[31];
            nb = (op[1:0] == 2'b00) && b[31];
            return 18 + int'(na | nb) + int'(na ^ nb);
        end
        na = !op[0] && a[31];
        nb = !op[0] && b[31];
        return 18 + int'(na | nb);
    endfunction

    // Starts one operation, waits for done, checks value and latency.
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
        int cyc = 0;
        logic [31:0] exp_r = ref_result(op, a, b);
        int exp_l = ref_lat(op, a, b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check(done_o == 1'b1 && result_o == exp_r, {tag, " result"}, result_o, exp_r);
        check(cyc + 2 == exp_l, {tag, " latency"}, 32'(cyc + 2), 32'(exp_l));
        @(negedge clk);
    endtask

    task automatic test_reset();
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 in reset", {30'h0, busy_o, done_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R1 after reset", {30'h0, busy_o, done_o}, 32'h0);
    endtask

    task automatic test_mul_unsigned();
        run_op(MULHU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 mulhu max");
        run_op(MULHU, 32'h1234_5678, 32'h9ABC_DEF0, "R2 mulhu mixed");
        run_op(3'b011, 32'h8000_0001, 32'h0000_0003, "R2 opcode 011");
    endtask

    task automatic test_mul_signed();
        run_op(MULH,   32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R4 mulh both neg");
        run_op(MULH,   32'h8000_0000, 32'h8000_0000, "R3 R4 mulh min sq");
        run_op(MULH,   32'hFFFF_FFFB, 32'h0000_0007, "R3 R4 mulh a neg");
        run_op(MULH,   32'h0000_0007, 32'hFFFF_FFFB, "R3 R4 mulh b neg");
        run_op(MULH,   32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 R4 mulh pos");
        run_op(MULH,   32'hFFFF_FFFF, 32'h0000_0000, "R3 R4 mulh neg by zero");
        run_op(MULHSU, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 R4 mulhsu neg a");
        run_op(MULHSU, 32'h0000_0005, 32'hFFFF_FFFF, "R3 R4 mulhsu pos a");
    endtask

    task automatic test_div_unsigned();
        run_op(DIVU, 32'd100, 32'd7, "R5 divu");
        run_op(REMU, 32'd100, 32'd7, "R5 remu");
        run_op(DIVU, 32'hFFFF_FFFF, 32'd1, "R5 divu by one");
        run_op(REMU, 32'd3, 32'd10, "R5 remu small");
        run_op(DIVU, 32'hFFFF_FFFF, 32'h8000_0000, "R5 divu high");
    endtask

    task automatic test_div_signed();
        run_op(DIV, 32'hFFFF_FFF9, 32'd2, "R6 div neg/pos");
        run_op(REM, 32'hFFFF_FFF9, 32'd2, "R6 rem neg/pos");
        run_op(DIV, 32'd7, 32'hFFFF_FFFE, "R6 div pos/neg");
        run_op(REM, 32'd7, 32'hFFFF_FFFE, "R6 rem pos/neg");
        run_op(DIV, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6 div neg/neg");
        run_op(REM, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R6 rem neg/neg");
        run_op(DIV, 32'd7, 32'd2, "R6 div pos/pos");
    endtask

    task automatic test_div_zero();
        run_op(DIVU, 32'h1234_5678, 32'd0, "R7 divu by zero");
        run_op(REMU, 32'h1234_5678, 32'd0, "R7 remu by zero");
        run_op(DIV,  32'hFFFF_FFF9, 32'd0, "R7 div neg by zero");
        run_op(REM,  32'hFFFF_FFF9, 32'd0, "R7 rem neg by zero");
        run_op(DIV,  32'd9, 32'd0, "R7 div pos by zero");
    endtask

    task automatic test_overflow();
        run_op(DIV, 32'h8000_0000, 32'hFFFF_FFFF, "R8 div overflow");
        run_op(REM, 32'h8000_0000, 32'hFFFF_FFFF, "R8 rem overflow");
    endtask

    task automatic test_busy_ignore();
        int cyc = 0;
        logic [31:0] exp_r = ref_result(DIVU, 32'd1000, 32'd9);
        @(negedge clk);
        start_i = 1'b1; op_i = DIVU; a_i = 32'd1000; b_i = 32'd9;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9 busy after start", {31'h0, busy_o}, 32'h1);
        while (!done_o && cyc < 40) begin
            // stray starts while busy
            start_i = (cyc % 3 == 1); op_i = MULH; a_i = 32'hFFFF_FFFF; b_i = 32'd5;
            @(negedge clk);
            cyc++;
            if (!done_o) check(busy_o == 1'b1, "R9 busy held", {31'h0, busy_o}, 32'h1);
        end
        start_i = 1'b0;
        check(done_o == 1'b1 && result_o == exp_r, "R9 result unaffected", result_o, exp_r);
        check(cyc + 2 == 18, "R9 latency unaffected", 32'(cyc + 2), 32'd18);
        // start raised in the done cycle must be ignored
        start_i = 1'b1; op_i = MULHU; a_i = 32'd3; b_i = 32'd4;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R9 done single pulse", {31'h0, done_o}, 32'h0);
        check(busy_o == 1'b0, "R9 start in done cycle ignored", {31'h0, busy_o}, 32'h0);
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0, "R9 still idle", {30'h0, busy_o, done_o}, 32'h0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_mul_unsigned();
        test_mul_signed();
        test_div_unsigned();
        test_div_signed();
        test_div_zero();
        test_overflow();
        test_busy_ignore();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule